// File: doc/BRIEF.md
# Variable Shift and Field Extract Unit

A 64-bit bit-manipulation unit for an integer pipeline. In one registered stage it performs register-driven shifts (left, arithmetic right, logical right) and extracts an arbitrary field from a source word. It also sign-extends or zero-extends a byte, half-word or word taken from the low end of the source. Shift amounts come from a full 64-bit register operand. Field position and length come from short instruction fields.

All operations share a single datapath. A decode stage turns each operation into four controls: a shift amount, a direction, a fill bit, and a field length. A barrel shifter then moves the data, and a masking stage keeps the low field bits and fills the upper bits with zeros or with the field's top bit. Extension reuses the extract path with position zero and a fixed length.

Top module: `bsx_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `valid_o` are zero.
- R2: `valid_o` is high in the cycle after each cycle in which `valid_i` is high, and low otherwise. `result_o` changes only on a clock edge where `valid_i` is high, and otherwise keeps its value.
- R3: Opcode 0 shifts `src_i` left by `amt_i` and fills zeros from the bottom. Any `amt_i` above 63 gives zero.
- R4: Opcode 1 shifts right by `amt_i` and fills the vacated upper bits with `src_i[63]`. Any `amt_i` above 63 gives 64 copies of `src_i[63]`.
- R5: Opcode 2 shifts right by `amt_i` and fills zeros. Any `amt_i` above 63 gives zero.
- R6: Opcode 3 (signed extract) places the field `src_i[pos_i +: len_m1_i+1]` in the low bits of the result. The bits above the field are copies of the field's top bit.
- R7: Opcode 4 (unsigned extract) places the same field in the low bits and zero-fills the bits above it.
- R8: If `pos_i + len_m1_i` exceeds 63, field bits above source bit 63 read as `src_i[63]` for opcode 3 and as zero for opcode 4.
- R9: Opcode 5 sign-extends the low 8, 16 or 32 bits of `src_i`, selected by `size_i` = 00, 01 or 10. The value 11 selects 32 bits.
- R10: Opcode 6 zero-extends the low 8, 16 or 32 bits of `src_i`, selected by `size_i` as in R9.
- R11: Opcode 7 is reserved and produces a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode (0 shl, 1 sar, 2 shr, 3 sext field, 4 zext field, 5 sign extend, 6 zero extend, 7 reserved) |
| src_i | input | 64 | Source operand |
| amt_i | input | 64 | Shift-amount register |
| pos_i | input | 6 | Field start bit |
| len_m1_i | input | 6 | Field length minus one |
| size_i | input | 2 | Extension size select |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result valid |

## Verification
The bench targets the following corner cases:
- **Shift amounts at 63, 64 and far above.** A design that looks only at the low six amount bits would wrap around instead of saturating.
- **Extract fields that cross bit 63.** A design that fills the missing bits from the wrong source would give the wrong sign for signed extract or leave garbage for unsigned extract.
- **A full 64-bit field and single-bit fields.** These expose off-by-one errors in the length mask.
- **Negative and positive sources at every extension size, including size code 11.** These catch a wrong sign bit or a wrong field width.
- **Idle cycles between strobes.** A design that updates the result register without a strobe would change its output when it should hold.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SAR  = 3'd1,
    OP_SHR  = 3'd2,
    OP_EXTS = 3'd3,
    OP_EXTU = 3'd4,
    OP_SXT  = 3'd5,
    OP_ZXT  = 3'd6,
    OP_RSV  = 3'd7
  } bsx_op_e;
endpackage

// File: rtl/bsx_decode.sv
module bsx_decode
  import bsx_pkg::*;
#(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  src_i,
  input  logic [W-1:0]  amt_i,
  input  logic [PW-1:0] pos_i,
  input  logic [PW-1:0] len_m1_i,
  input  logic [1:0]    size_i,
  output logic [PW-1:0] shamt_o,
  output logic          left_o,
  output logic          fill_o,
  output logic          over_o,
  output logic [PW-1:0] len_o,
  output logic          sext_o,
  output logic          kill_o
);
  localparam logic [PW-1:0] LEN_FULL = PW'(W - 1);
  localparam logic [PW-1:0] LEN_B    = PW'(7);
  localparam logic [PW-1:0] LEN_H    = PW'(15);
  localparam logic [PW-1:0] LEN_WD   = PW'(31);

  logic amt_big;
  logic [PW-1:0] ext_len;

  assign amt_big = |amt_i[W-1:PW];

  always_comb begin
    unique case (size_i)
      2'b00:   ext_len = LEN_B;
      2'b01:   ext_len = LEN_H;
      default: ext_len = LEN_WD;
    endcase
  end

  always_comb begin
    shamt_o = '0;
    left_o  = 1'b0;
    fill_o  = 1'b0;
    over_o  = 1'b0;
    len_o   = LEN_FULL;
    sext_o  = 1'b0;
    kill_o  = 1'b0;
    unique case (bsx_op_e'(op_i))
      OP_SHL: begin
        shamt_o = amt_i[PW-1:0];
        left_o  = 1'b1;
        over_o  = amt_big;
      end
      OP_SAR: begin
        shamt_o = amt_i[PW-1:0];
        fill_o  = src_i[W-1];
        over_o  = amt_big;
      end
      OP_SHR: begin
        shamt_o = amt_i[PW-1:0];
        over_o  = amt_big;
      end
      OP_EXTS: begin
        shamt_o = pos_i;
        fill_o  = src_i[W-1];
        len_o   = len_m1_i;
        sext_o  = 1'b1;
      end
      OP_EXTU: begin
        shamt_o = pos_i;
        len_o   = len_m1_i;
      end
      OP_SXT: begin
        len_o  = ext_len;
        sext_o = 1'b1;
      end
      OP_ZXT: len_o = ext_len;
      default: kill_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bsx_shifter.sv
module bsx_shifter #(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [PW-1:0] shamt_i,
  input  logic          left_i,
  input  logic          fill_i,
  input  logic          over_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] rev_in, rev_out, pre;
  logic [W-1:0] stg [PW+1];

  // left shift = reversed right shift with zero fill
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[PW][W-1-i];
  end

  assign pre    = left_i ? rev_in : data_i;
  assign stg[0] = pre;

  for (genvar k = 0; k < PW; k++) begin : g_stage
    localparam int S = 2 ** k;
    assign stg[k+1] = shamt_i[k] ? {{S{fill_i}}, stg[k][W-1:S]} : stg[k];
  end

  assign data_o = over_i ? {W{fill_i}} : (left_i ? rev_out : stg[PW]);
endmodule

// File: rtl/bsx_mask.sv
module bsx_mask #(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [PW-1:0] len_i,
  input  logic          sext_i,
  input  logic          kill_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] keep;
  logic         top;

  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep[i] = (len_i >= PW'(i));
  end

  assign top    = sext_i & data_i[len_i];
  assign data_o = kill_i ? '0 : ((data_i & keep) | ({W{top}} & ~keep));
endmodule

// File: rtl/bsx_unit.sv
module bsx_unit
  import bsx_pkg::*;
#(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  src_i,
  input  logic [W-1:0]  amt_i,
  input  logic [PW-1:0] pos_i,
  input  logic [PW-1:0] len_m1_i,
  input  logic [1:0]    size_i,
  output logic [W-1:0]  result_o,
  output logic          valid_o
);
  logic [PW-1:0] shamt, len;
  logic          left, fill, over, sext, kill;
  logic [W-1:0]  shifted, res_d;

  bsx_decode #(.W(W), .PW(PW)) u_dec (
    .op_i(op_i), .src_i(src_i), .amt_i(amt_i), .pos_i(pos_i),
    .len_m1_i(len_m1_i), .size_i(size_i),
    .shamt_o(shamt), .left_o(left), .fill_o(fill), .over_o(over),
    .len_o(len), .sext_o(sext), .kill_o(kill)
  );

  bsx_shifter #(.W(W), .PW(PW)) u_shf (
    .data_i(src_i), .shamt_i(shamt), .left_i(left), .fill_i(fill),
    .over_i(over), .data_o(shifted)
  );

  bsx_mask #(.W(W), .PW(PW)) u_msk (
    .data_i(shifted), .len_i(len), .sext_i(sext), .kill_i(kill),
    .data_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  // R3
  shl_over_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'(OP_SHL) && |amt_i[W-1:PW]) |=> result_o == '0);
  // R7
  extu_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'(OP_EXTU))
      |=> (result_o >> ({1'b0, $past(len_m1_i)} + 7'd1)) == '0);
  // R10
  zxt_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'(OP_ZXT) && size_i == 2'b00) |=> result_o[W-1:8] == '0);
  // R11
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'(OP_RSV)) |=> result_o == '0);
endmodule

// File: tb/tb_bsx_unit.sv
module tb_bsx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] src_i = '0, amt_i = '0;
  logic [5:0]  pos_i = '0, len_m1_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int n_cmp = 0, n_bad = 0;
  logic [63:0] exp_res = '0;
  logic        exp_vld = 1'b0;
  string       exp_tag = "R1";

  always #5 clk_i = ~clk_i;

  bsx_unit dut (.*);

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] s,
      input logic [63:0] a, input int pos, input int lm1, input logic [1:0] sz);
    logic [63:0] r = '0;
    int n;
    logic sg;
    case (op)
      3'd0: r = (a > 63) ? 64'd0 : s << a[5:0];
      3'd1: r = (a > 63) ? {64{s[63]}} : 64'($signed(s) >>> a[5:0]);
      3'd2: r = (a > 63) ? 64'd0 : s >> a[5:0];
      3'd3, 3'd4: begin
        for (int i = 0; i <= lm1; i++)
          r[i] = (pos + i < 64) ? s[pos+i] : ((op == 3'd3) ? s[63] : 1'b0);
        sg = (op == 3'd3) ? r[lm1] : 1'b0;
        for (int i = lm1 + 1; i < 64; i++) r[i] = sg;
      end
      3'd5, 3'd6: begin
        n = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        for (int i = 0; i < n; i++) r[i] = s[i];
        sg = (op == 3'd5) ? s[n-1] : 1'b0;
        for (int i = n; i < 64; i++) r[i] = sg;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input int pos, input int lm1);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return (pos + lm1 > 63) ? "R8" : "R6";
      3'd4: return (pos + lm1 > 63) ? "R8" : "R7";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (valid_o !== exp_vld || result_o !== exp_res) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b result=%h, expected valid=%0b result=%h",
               tag, valid_o, result_o, exp_vld, exp_res);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(input logic v, input logic [2:0] op, input logic [63:0] s,
      input logic [63:0] a, input logic [5:0] p, input logic [5:0] l, input logic [1:0] sz);
    valid_i = v; op_i = op; src_i = s; amt_i = a; pos_i = p; len_m1_i = l; size_i = sz;
    exp_vld = v;
    if (v) begin
      exp_res = model(op, s, a, int'(p), int'(l), sz);
      exp_tag = tag_of(op, int'(p), int'(l));
    end else exp_tag = "R2";
    @(negedge clk_i);
    check(exp_tag);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] neg = 64'hF0F0_1234_8765_A5C3;
    logic [63:0] pos = 64'h7A5A_0F0F_C3C3_1881;
    // R1: reset holds outputs at zero even with a strobe
    valid_i = 1'b1; op_i = 3'd2; src_i = neg;
    repeat (3) @(negedge clk_i);
    exp_vld = 1'b0; exp_res = '0; check("R1");
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i); check("R1");

    // R3..R5 shift corners
    foreach (neg[k]) begin end
    for (int i = 0; i < 3; i++) begin
      step(1, 3'(i), neg, 64'd0,  '0, '0, '0);
      step(1, 3'(i), neg, 64'd1,  '0, '0, '0);
      step(1, 3'(i), neg, 64'd63, '0, '0, '0);
      step(1, 3'(i), neg, 64'd64, '0, '0, '0);
      step(1, 3'(i), pos, 64'd65, '0, '0, '0);
      step(1, 3'(i), neg, 64'h8000_0000_0000_0003, '0, '0, '0);
      step(1, 3'(i), pos, 64'd17, '0, '0, '0);
    end
    // R6/R7/R8 extract corners
    for (int o = 3; o <= 4; o++) begin
      step(1, 3'(o), neg, '0, 6'd0,  6'd63, '0);
      step(1, 3'(o), neg, '0, 6'd63, 6'd0,  '0);
      step(1, 3'(o), pos, '0, 6'd63, 6'd63, '0);
      step(1, 3'(o), neg, '0, 6'd60, 6'd7,  '0);
      step(1, 3'(o), neg, '0, 6'd4,  6'd11, '0);
      step(1, 3'(o), pos, '0, 6'd7,  6'd0,  '0);
      step(1, 3'(o), neg, '0, 6'd15, 6'd0,  '0);
    end
    // R9/R10 all size codes, both signs
    for (int o = 5; o <= 6; o++)
      for (int z = 0; z < 4; z++) begin
        step(1, 3'(o), 64'h0123_4567_89AB_CDEF, '0, '0, '0, 2'(z));
        step(1, 3'(o), 64'h89AB_CDEF_7654_3210, '0, '0, '0, 2'(z));
        step(1, 3'(o), 64'hFFFF_FFFF_0000_7F7F, '0, '0, '0, 2'(z));
      end
    // R11 reserved
    step(1, 3'd7, neg, 64'd3, 6'd5, 6'd5, 2'd1);
    // R2 idle hold with changing inputs
    step(1, 3'd0, pos, 64'd4, '0, '0, '0);
    step(0, 3'd2, neg, 64'd1, '0, '0, '0);
    step(0, 3'd7, pos, 64'd9, 6'd3, 6'd3, '0);
    // random mix with idle gaps
    for (int t = 0; t < 3000; t++) begin
      logic [63:0] a = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) a = 64'($urandom_range(0, 70));
      step(1'($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)),
           {$urandom, $urandom}, a, 6'($urandom), 6'($urandom), 2'($urandom));
    end
    // R1 asynchronous reset mid-run
    step(1, 3'd2, neg, 64'd2, '0, '0, '0);
    #2 rst_ni = 1'b0;
    #1 exp_vld = 1'b0; exp_res = '0; check("R1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule